// File: doc/BRIEF.md
# Dual-Byte 8B/10B Line Encoder

This block turns two bytes per clock into one 20-bit word of two 10-bit transmission characters. Each byte goes through its own encoding slice: a five-to-six-bit stage and a three-to-four-bit stage. The slices are chained combinationally. The running disparity left by the low byte is the starting disparity of the high byte in the same cycle. The disparity left by the high byte is stored and seeds the low byte of the next accepted word.

A per-byte flag picks the ordinary data character or the special (control) character for that byte. The block does not check whether a byte flagged as control is one of the twelve legal specials. Whatever value arrives is encoded, and nothing is reported. The 20-bit result is registered, so it appears one clock after the word is accepted. Words are accepted only while the valid strobe is high.

Top module: `dual_byte_8b10b_enc`

## Requirements
- R1: Input bits 7:0 form the low byte, governed by flag bit 0, and their character lands on output bits 9:0. Input bits 15:8 form the high byte, governed by flag bit 1, and their character lands on output bits 19:10.
- R2: A flag of 0 selects the data character Dx.y for its byte and a flag of 1 selects the control character Kx.y, where x is byte bits 4:0 and y is byte bits 7:5. Example: byte 8'hBC with flag 1 gives K28.5, and with flag 0 gives D28.5.
- R3: Within each 10-bit character the bits are ordered a,b,c,d,e,i,f,g,h,j from the least significant bit up. From negative disparity, K28.5 is 10'h17C and D28.5 is 10'h15C.
- R4: Within one cycle the high byte starts from the disparity that the low byte ends with.
- R5: The disparity after the high byte of an accepted word is the starting disparity of the low byte of the next accepted word. For example, word 16'hBCBC with flags 2'b01 encodes as 20'h5717C from negative disparity and as 20'h57283 from positive disparity.
- R6: A synchronous active-high reset clears the output to zero and sets the running disparity to negative.
- R7: While the valid strobe is low, the output keeps its value and the running disparity does not move.
- R8: Control values are not validated. Byte 8'h38 with its flag set, starting from positive disparity, yields 10'h18C, which has the same bits as a legal data character.
- R9: For y=7 the alternate four-bit form is used in three cases: for data x = 17, 18, 20 when the disparity after the six-bit stage is negative; for data x = 11, 13, 14 when it is positive; and for every control byte. The primary form is used otherwise.
- R10: The balanced sub-blocks whose form depends on disparity are x=7 and y=3. At negative disparity they take the forms abcdei=111000 and fghj=1100. At positive disparity they take the complements.
- R11: Every character holds four to six ones. From negative disparity it never has more zeros than ones, and from positive disparity it never has more ones than zeros. The running disparity flips only after an unbalanced character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the word on in_data / in_ctrl this cycle |
| in_data | input | 16 | Two bytes, low byte in bits 7:0 |
| in_ctrl | input | 2 | Per-byte control flag, bit 0 for the low byte |
| enc_out | output | 20 | Registered pair of 10-bit characters, low character in bits 9:0 |

## Verification
The disparity and weight properties sample the slice chain only in cycles where in_valid is high. They assume that in_data and in_ctrl carry known values whenever the strobe is high. The hold and reset properties assume the clock runs and that reset is driven to a known level from the first edge. The stimulus sets every input at a falling edge, keeps data and flags defined even while the strobe is low, and holds reset high from time zero. It includes an illegal control byte, because the disparity bounds must hold for such characters as well.

// File: rtl/enc8b10b_pkg.sv
package enc8b10b_pkg;

  localparam int unsigned SYM_W  = 8;
  localparam int unsigned CODE_W = 10;
  localparam int unsigned X_W    = 5;
  localparam int unsigned Y_W    = 3;

  // running disparity encoding: 0 = negative, 1 = positive
  localparam logic RD_NEG = 1'b0;
  localparam logic RD_POS = 1'b1;

  function automatic logic [5:0] rev6(input logic [5:0] v);
    logic [5:0] r;
    for (int n = 0; n < 6; n++) r[n] = v[5-n];
    return r;
  endfunction

  function automatic logic [3:0] rev4(input logic [3:0] v);
    logic [3:0] r;
    for (int n = 0; n < 4; n++) r[n] = v[3-n];
    return r;
  endfunction

  function automatic logic [2:0] ones6(input logic [5:0] v);
    logic [2:0] s;
    s = '0;
    for (int n = 0; n < 6; n++) s = s + {2'b00, v[n]};
    return s;
  endfunction

  function automatic logic [2:0] ones4(input logic [3:0] v);
    logic [2:0] s;
    s = '0;
    for (int n = 0; n < 4; n++) s = s + {2'b00, v[n]};
    return s;
  endfunction

endpackage

// File: rtl/enc_5b6b.sv
module enc_5b6b
  import enc8b10b_pkg::*;
(
  input  logic [X_W-1:0] x_i,
  input  logic           k_i,
  input  logic           rd_i,
  output logic [5:0]     sb6_o,   // bit 0 = a ... bit 5 = i
  output logic           rd_o
);

  // negative-disparity form, written abcdei with a in the MSB position
  logic [5:0] base;
  logic       unbal;
  logic       flip;

  always_comb begin
    case (x_i)
      5'd0:  base = 6'b100111;
      5'd1:  base = 6'b011101;
      5'd2:  base = 6'b101101;
      5'd3:  base = 6'b110001;
      5'd4:  base = 6'b110101;
      5'd5:  base = 6'b101001;
      5'd6:  base = 6'b011001;
      5'd7:  base = 6'b111000;
      5'd8:  base = 6'b111001;
      5'd9:  base = 6'b100101;
      5'd10: base = 6'b010101;
      5'd11: base = 6'b110100;
      5'd12: base = 6'b001101;
      5'd13: base = 6'b101100;
      5'd14: base = 6'b011100;
      5'd15: base = 6'b010111;
      5'd16: base = 6'b011011;
      5'd17: base = 6'b100011;
      5'd18: base = 6'b010011;
      5'd19: base = 6'b110010;
      5'd20: base = 6'b001011;
      5'd21: base = 6'b101010;
      5'd22: base = 6'b011010;
      5'd23: base = 6'b111010;
      5'd24: base = 6'b110011;
      5'd25: base = 6'b100110;
      5'd26: base = 6'b010110;
      5'd27: base = 6'b110110;
      5'd28: base = k_i ? 6'b001111 : 6'b001110;
      5'd29: base = 6'b101110;
      5'd30: base = 6'b011110;
      default: base = 6'b101011;
    endcase
  end

  assign unbal = (ones6(base) != 3'd3);
  // complement at positive disparity: unbalanced blocks and the x=7 special
  assign flip  = (rd_i == RD_POS) && (unbal || (x_i == 5'd7));
  assign sb6_o = rev6(flip ? ~base : base);
  assign rd_o  = unbal ? ~rd_i : rd_i;

endmodule

// File: rtl/enc_3b4b.sv
module enc_3b4b
  import enc8b10b_pkg::*;
(
  input  logic [Y_W-1:0] y_i,
  input  logic [X_W-1:0] x_i,
  input  logic           k_i,
  input  logic           rd_i,    // disparity after the six-bit stage
  output logic [3:0]     sb4_o,   // bit 0 = f ... bit 3 = j
  output logic           rd_o
);

  logic [3:0] base;   // negative-disparity form, fghj with f in the MSB position
  logic       use_alt;
  logic       unbal;
  logic       k_swap;
  logic       flip;

  // alternate x.7: avoids a run of five equal bits across the sub-block seam
  assign use_alt = (y_i == 3'd7) &&
                   (k_i ||
                    ((rd_i == RD_NEG) && ((x_i == 5'd17) || (x_i == 5'd18) || (x_i == 5'd20))) ||
                    ((rd_i == RD_POS) && ((x_i == 5'd11) || (x_i == 5'd13) || (x_i == 5'd14))));

  always_comb begin
    case (y_i)
      3'd0: base = 4'b1011;
      3'd1: base = 4'b1001;
      3'd2: base = 4'b0101;
      3'd3: base = 4'b1100;
      3'd4: base = 4'b1101;
      3'd5: base = 4'b1010;
      3'd6: base = 4'b0110;
      default: base = use_alt ? 4'b0111 : 4'b1110;
    endcase
  end

  assign unbal  = (ones4(base) != 3'd2);
  // control characters invert the balanced y=1,2,5,6 forms after a negative six-bit stage
  assign k_swap = k_i && !unbal && (y_i != 3'd3) && (rd_i == RD_NEG);
  assign flip   = ((rd_i == RD_POS) && (unbal || (y_i == 3'd3))) || k_swap;
  assign sb4_o  = rev4(flip ? ~base : base);
  assign rd_o   = unbal ? ~rd_i : rd_i;

endmodule

// File: rtl/enc_slice.sv
module enc_slice
  import enc8b10b_pkg::*;
(
  input  logic [SYM_W-1:0]  sym_i,
  input  logic              k_i,
  input  logic              rd_i,
  output logic [CODE_W-1:0] code_o,
  output logic              rd_o
);

  logic [5:0] sb6;
  logic [3:0] sb4;
  logic       rd_mid;

  enc_5b6b u_5b6b (
    .x_i   (sym_i[X_W-1:0]),
    .k_i   (k_i),
    .rd_i  (rd_i),
    .sb6_o (sb6),
    .rd_o  (rd_mid)
  );

  enc_3b4b u_3b4b (
    .y_i   (sym_i[SYM_W-1:X_W]),
    .x_i   (sym_i[X_W-1:0]),
    .k_i   (k_i),
    .rd_i  (rd_mid),
    .sb4_o (sb4),
    .rd_o  (rd_o)
  );

  assign code_o = {sb4, sb6};

endmodule

// File: rtl/dual_byte_8b10b_enc.sv
module dual_byte_8b10b_enc
  import enc8b10b_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [LANES*SYM_W-1:0]   in_data,
  input  logic [LANES-1:0]         in_ctrl,
  output logic [LANES*CODE_W-1:0]  enc_out
);

  localparam int unsigned DIN_W  = LANES * SYM_W;
  localparam int unsigned DOUT_W = LANES * CODE_W;

  logic                rd_q;
  logic [LANES:0]      rd_chain;
  logic [CODE_W-1:0]   lane_code [LANES];
  logic [DOUT_W-1:0]   code_w;
  logic [DOUT_W-1:0]   enc_q;

  assign rd_chain[0] = rd_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    enc_slice u_slice (
      .sym_i  (in_data[g*SYM_W +: SYM_W]),
      .k_i    (in_ctrl[g]),
      .rd_i   (rd_chain[g]),
      .code_o (lane_code[g]),
      .rd_o   (rd_chain[g+1])
    );
    assign code_w[g*CODE_W +: CODE_W] = lane_code[g];

    // R11: weight of every character stays within four to six ones
    p_weight_r11 : assert property (@(posedge clk) disable iff (rst)
      in_valid |-> (($countones(lane_code[g]) >= 4) && ($countones(lane_code[g]) <= 6)));

    // R4, R11: character disparity agrees with the disparity this lane starts from
    p_start_sign_r4 : assert property (@(posedge clk) disable iff (rst)
      in_valid |-> ((rd_chain[g] == RD_POS) ? ($countones(lane_code[g]) <= 5)
                                            : ($countones(lane_code[g]) >= 5)));

    // R4: the disparity handed to the next lane moves only on an unbalanced character
    p_hand_on_r4 : assert property (@(posedge clk) disable iff (rst)
      in_valid |-> (($countones(lane_code[g]) == 5) ? (rd_chain[g+1] == rd_chain[g])
                                                    : (rd_chain[g+1] == ($countones(lane_code[g]) > 5))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= RD_NEG;
      enc_q <= '0;
    end else if (in_valid) begin
      rd_q  <= rd_chain[LANES];
      enc_q <= code_w;
    end
  end

  assign enc_out = enc_q;

  // R6: reset leaves a zero output word
  p_reset_zero_r6 : assert property (@(posedge clk)
    rst |=> (enc_out == '0));

  // R7: an idle strobe keeps the output word
  p_idle_hold_r7 : assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(enc_out));

  // R6: a word accepted right after reset starts from negative disparity
  p_first_neg_r6 : assert property (@(posedge clk)
    (rst && $past(rst)) |=> (rd_chain[0] == RD_NEG));

  initial begin
    if (DIN_W != LANES * 8) $error("lane width mismatch");
  end

endmodule

// File: tb/sim_dual_byte_8b10b_enc.sv
module sim_dual_byte_8b10b_enc;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [1:0]  in_ctrl = '0;
  logic [19:0] enc_out;

  int nchk  = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  dual_byte_8b10b_enc #(.LANES(2)) u0 (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ctrl  (in_ctrl),
    .enc_out  (enc_out)
  );

  task automatic check(input string req, input logic [19:0] exp);
    nchk++;
    if (enc_out !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, enc_out, exp);
    end
  endtask

  // drive one word at a falling edge, sample after the register edge
  task automatic send(input string req, input logic [15:0] d, input logic [1:0] c,
                      input logic [19:0] exp);
    @(negedge clk);
    in_data  = d;
    in_ctrl  = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, exp);
  endtask

  task automatic t_reset_state;
    repeat (3) @(negedge clk);
    check("R6 reset output", 20'h00000);
    rst = 1'b0;
  endtask

  task automatic t_comma_pair;
    // K28.5 low, D28.5 high from negative disparity (R1 R2 R3)
    send("R1 R2 R3 BCBC flags 01 from RD-", 16'hBCBC, 2'b01, 20'h5717C);
    // carried disparity is now positive (R5)
    send("R5 BCBC flags 01 from RD+", 16'hBCBC, 2'b01, 20'h57283);
    send("R5 BCBC flags 01 back at RD-", 16'hBCBC, 2'b01, 20'h5717C);
  endtask

  task automatic t_unchecked_ctrl;
    // RD+: K24.1 -> 10'h18C, high D0.0 starts at RD- left by low byte (R8 R4)
    send("R8 R4 illegal control 0x38", 16'h0038, 2'b01, 20'h2E58C);
  endtask

  task automatic t_idle_hold;
    @(negedge clk);
    in_data = 16'hFFFF;
    in_ctrl = 2'b11;
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      check("R7 idle hold", 20'h2E58C);
    end
  endtask

  task automatic t_alt_seven;
    // D17.7 at RD- and D11.7 at RD+ both take the alternate form (R9); also shows R7 kept RD-
    send("R9 R7 alternate x.7 data", 16'hEBF1, 2'b00, 20'h12FB1);
    // K28.7 in both lanes (R9 R11)
    send("R9 R11 K28.7 pair", 16'hFCFC, 2'b11, 20'h1F07C);
  endtask

  task automatic t_special_forms;
    send("R5 BCBC to reach RD+", 16'hBCBC, 2'b01, 20'h5717C);
    // D7.0 at RD+ then at RD- (R10)
    send("R10 D7.0 pair", 16'h0707, 2'b00, 20'hD1CB8);
  endtask

  task automatic t_mid_reset;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R6 mid-run reset", 20'h00000);
    // high lane flagged only: D28.5 low, K28.5 high from RD- (R1 R6)
    send("R1 R6 BCBC flags 10", 16'hBCBC, 2'b10, 20'h5F15C);
    // D3.3 at RD+ both lanes (R10)
    send("R10 D3.3 pair at RD+", 16'h6363, 2'b00, 20'hC8F23);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_comma_pair();
    t_unchecked_ctrl();
    t_idle_hold();
    t_alt_seven();
    t_special_forms();
    t_mid_reset();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule